// File: doc/BRIEF.md
# Add-Immediate Execute Unit (Short and Prefixed Forms)

This unit executes an add-immediate operation in two encodings. The short form uses one 32-bit word that carries a 16-bit signed constant. The long form uses a prefix word followed by a suffix word, and together they carry a 34-bit signed constant. In the long form a relative flag can replace the base operand with the program counter. The caller presents the instruction word(s), the current program counter and the value of the register selected by the base field. The unit returns four things:
- the 64-bit sum;
- the destination index with its write enable;
- the following program counter;
- flags that report an illegal encoding and whether the suffix word was consumed.

There is one register stage. A request strobed on `in_valid` produces exactly one result strobe on `out_valid` on the next clock. There is no ready signal and no back-pressure: the consumer must take every result in the cycle it appears. A new request may be issued every cycle. Carry, overflow and condition flags are never produced.

Top module: `addimm_exec`

## Requirements
- R1: `out_valid` is high in the cycle that follows each cycle with `in_valid` high, and low after each cycle with `in_valid` low. The result fields belong to the request of that previous cycle.
- R2: The short form is recognised when word0[31:26] equals 14. Its destination index is word0[25:21] and its base index is word0[20:16]. The result is the base value plus word0[15:0] sign-extended, and the write enable is 1.
- R3: For a legal request, the next program counter is pc+4 for the short form and pc+8 for the long form.
- R4: `out_suffix_used` is 0 for the short form. For a prefix word it is 1 exactly when `word1_valid` is high.
- R5: The long form is recognised when word0[31:24] equals 0x06 and word1 is valid with word1[31:26] equal to 14. Its constant is the signed 34-bit value {word0[17:0], word1[15:0]}, sign-extended to 64 bits. The destination and base indices come from word1[25:21] and word1[20:16].
- R6: In the long form with word0[20] (the relative flag) set and base index 0, the result is pc plus the constant.
- R7: In the short form, and in the long form with the relative flag clear, a base index of 0 selects the constant zero rather than `ra_value`. Any other index uses `ra_value`.
- R8: The long form with the relative flag set and a nonzero base index is illegal.
- R9: These cases are illegal:
  - a prefix word without a valid suffix;
  - a prefix word whose suffix has word1[31:26] other than 14;
  - a word0 that matches neither form.
- R10: An illegal result has write enable 0, result 0, destination 0, and next program counter equal to pc.
- R11: The sum wraps modulo 2^64.
- R12: While reset is active, and after it is released, `out_valid` is 0 until the first request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| word0 | input | 32 | First instruction word (short form or prefix) |
| word1_valid | input | 1 | Suffix word present |
| word1 | input | 32 | Suffix word |
| pc | input | 64 | Program counter of the instruction |
| ra_value | input | 64 | Value of the register named by the base field |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Sum to write back |
| out_rt | output | 5 | Destination register index |
| out_wr_en | output | 1 | Destination write enable |
| out_next_pc | output | 64 | Following program counter |
| out_illegal | output | 1 | Encoding not accepted |
| out_suffix_used | output | 1 | Suffix word consumed |

## Verification
The assertions assume that `word0`, `word1`, `word1_valid`, `pc` and `ra_value` are settled and stable around each clock edge while `in_valid` is high. They also assume that the caller presents the register value matching the base field, since the unit cannot see the register file. The stimulus changes inputs only on the falling clock edge and issues requests back to back, with occasional idle gaps. Its encodings place every field explicitly, so each request hits exactly the form, relative-flag and base-index corner it is meant to exercise.

// File: rtl/addimm_pkg.sv
package addimm_pkg;
  localparam int unsigned OPC_W      = 6;
  localparam int unsigned REG_IDX_W  = 5;
  localparam int unsigned SHORT_IMM_W = 16;
  localparam int unsigned LONG_HI_W  = 18;
  localparam int unsigned LONG_IMM_W = SHORT_IMM_W + LONG_HI_W;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd14;
  localparam logic [7:0]       PFX_TAG  = 8'h06;
  localparam int unsigned      REL_BIT  = 20;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_SHORT = 2'd1,
    FORM_LONG  = 2'd2
  } form_e;

  typedef struct packed {
    form_e                 form;
    logic                  illegal;
    logic                  suffix_used;
    logic                  use_pc;
    logic [REG_IDX_W-1:0]  rt;
    logic [REG_IDX_W-1:0]  ra;
    logic [LONG_IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/addimm_decode.sv
module addimm_decode
  import addimm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] word0,
  input  logic        word1_valid,
  input  logic [31:0] word1,
  output dec_t        dec
);
  logic short_hit, pfx_hit, sfx_ok;

  assign short_hit = (word0[31:32-OPC_W] == OPC_ADDI);
  assign pfx_hit   = (word0[31:24] == PFX_TAG);
  assign sfx_ok    = word1_valid && (word1[31:32-OPC_W] == OPC_ADDI);

  always_comb begin
    dec         = '0;
    dec.form    = FORM_NONE;
    dec.illegal = 1'b1;
    if (short_hit) begin
      dec.form    = FORM_SHORT;
      dec.illegal = 1'b0;
      dec.rt      = word0[25:21];
      dec.ra      = word0[20:16];
      dec.imm     = {{LONG_HI_W{word0[SHORT_IMM_W-1]}}, word0[SHORT_IMM_W-1:0]};
    end else if (pfx_hit) begin
      dec.suffix_used = word1_valid;
      if (sfx_ok) begin
        dec.form    = FORM_LONG;
        dec.use_pc  = word0[REL_BIT];
        dec.rt      = word1[25:21];
        dec.ra      = word1[20:16];
        dec.imm     = {word0[LONG_HI_W-1:0], word1[SHORT_IMM_W-1:0]};
        dec.illegal = word0[REL_BIT] && (word1[20:16] != '0);
      end
    end
  end

  // R9: a prefix with no suffix can never be accepted
  assert_prefix_needs_suffix_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_hit && !word1_valid) |-> (dec.illegal && dec.form == FORM_NONE));

  // R8: relative addressing forbids a nonzero base register
  assert_rel_base_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.form == FORM_LONG && dec.use_pc && dec.ra != '0) |-> dec.illegal);

  // R4: short form never consumes the suffix
  assert_short_no_suffix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.form == FORM_SHORT) |-> !dec.suffix_used);
endmodule

// File: rtl/addimm_adder.sv
module addimm_adder
  import addimm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]       pc,
  input  logic [XLEN-1:0]       ra_value,
  input  logic                  use_pc,
  input  logic [REG_IDX_W-1:0]  ra,
  input  logic [LONG_IMM_W-1:0] imm,
  output logic [XLEN-1:0]       sum
);
  localparam int unsigned EXT_W = XLEN - LONG_IMM_W;
  logic [XLEN-1:0] base, imm_ext;

  always_comb begin
    if (use_pc)           base = pc;
    else if (ra == '0)    base = '0;
    else                  base = ra_value;
  end

  assign imm_ext = {{EXT_W{imm[LONG_IMM_W-1]}}, imm};
  assign sum     = base + imm_ext;
endmodule

// File: rtl/addimm_pcstep.sv
module addimm_pcstep
  import addimm_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  form_e           form,
  input  logic            illegal,
  output logic [XLEN-1:0] next_pc
);
  localparam logic [XLEN-1:0] STEP1 = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * WORD_BYTES);

  always_comb begin
    if (illegal)                 next_pc = pc;
    else if (form == FORM_LONG)  next_pc = pc + STEP2;
    else                         next_pc = pc + STEP1;
  end
endmodule

// File: rtl/addimm_exec.sv
module addimm_exec
  import addimm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [31:0]          word0,
  input  logic                 word1_valid,
  input  logic [31:0]          word1,
  input  logic [XLEN-1:0]      pc,
  input  logic [XLEN-1:0]      ra_value,
  output logic                 out_valid,
  output logic [XLEN-1:0]      out_result,
  output logic [REG_IDX_W-1:0] out_rt,
  output logic                 out_wr_en,
  output logic [XLEN-1:0]      out_next_pc,
  output logic                 out_illegal,
  output logic                 out_suffix_used
);
  dec_t            dec;
  logic [XLEN-1:0] sum, npc;

  addimm_decode u_decode (
    .clk(clk), .rst_n(rst_n), .word0(word0),
    .word1_valid(word1_valid), .word1(word1), .dec(dec)
  );

  addimm_adder #(.XLEN(XLEN)) u_adder (
    .pc(pc), .ra_value(ra_value), .use_pc(dec.use_pc),
    .ra(dec.ra), .imm(dec.imm), .sum(sum)
  );

  addimm_pcstep #(.XLEN(XLEN), .WORD_BYTES(4)) u_pcstep (
    .pc(pc), .form(dec.form), .illegal(dec.illegal), .next_pc(npc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_result      <= '0;
      out_rt          <= '0;
      out_wr_en       <= 1'b0;
      out_next_pc     <= '0;
      out_illegal     <= 1'b0;
      out_suffix_used <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal     <= dec.illegal;
        out_suffix_used <= dec.suffix_used;
        out_next_pc     <= npc;
        out_wr_en       <= !dec.illegal;
        out_result      <= dec.illegal ? '0 : sum;
        out_rt          <= dec.illegal ? '0 : dec.rt;
      end
    end
  end

  // R1: one result per request, one cycle later
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10: illegal results never write
  assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_wr_en && out_result == '0));

  // R3: program counter step per form
  assert_step_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.form == FORM_SHORT) |=> (out_next_pc == $past(pc) + XLEN'(4)));
  assert_step_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.form == FORM_LONG && !dec.illegal) |=> (out_next_pc == $past(pc) + XLEN'(8)));
endmodule

// File: tb/addimm_exec_tb.sv
`timescale 1ns/1ps
module addimm_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] word0 = '0;
  logic        word1_valid = 1'b0;
  logic [31:0] word1 = '0;
  logic [63:0] pc = '0;
  logic [63:0] ra_value = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_rt;
  logic        out_wr_en;
  logic [63:0] out_next_pc;
  logic        out_illegal;
  logic        out_suffix_used;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  addimm_exec u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word0(word0),
    .word1_valid(word1_valid), .word1(word1), .pc(pc), .ra_value(ra_value),
    .out_valid(out_valid), .out_result(out_result), .out_rt(out_rt),
    .out_wr_en(out_wr_en), .out_next_pc(out_next_pc), .out_illegal(out_illegal),
    .out_suffix_used(out_suffix_used)
  );

  typedef struct packed {
    logic [63:0] res;
    logic [4:0]  rt;
    logic        wr;
    logic [63:0] npc;
    logic        ill;
    logic        used;
  } exp_t;

  exp_t        sb_q[$];
  string       tag_q[$];

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_short(logic [4:0] rt, logic [4:0] ra, logic [15:0] imm);
    return {6'd14, rt, ra, imm};
  endfunction

  function automatic logic [31:0] enc_pfx(logic rel, logic [17:0] hi);
    return {8'h06, 3'b000, rel, 2'b00, hi};
  endfunction

  // Reference model built from the requirement text
  function automatic exp_t model(logic [31:0] w0, logic w1v, logic [31:0] w1,
                                 logic [63:0] p, logic [63:0] rv);
    exp_t e;
    logic signed [33:0] c34;
    logic signed [15:0] c16;
    logic [63:0] base;
    e = '0;
    e.ill = 1'b1;
    e.npc = p;
    if (w0[31:26] == 6'd14) begin
      c16    = signed'(w0[15:0]);
      base   = (w0[20:16] == 5'd0) ? 64'd0 : rv;
      e.ill  = 1'b0;
      e.res  = base + 64'(c16);
      e.rt   = w0[25:21];
      e.wr   = 1'b1;
      e.npc  = p + 64'd4;
    end else if (w0[31:24] == 8'h06) begin
      e.used = w1v;
      if (w1v && w1[31:26] == 6'd14 && !(w0[20] && w1[20:16] != 5'd0)) begin
        c34   = signed'({w0[17:0], w1[15:0]});
        base  = w0[20] ? p : ((w1[20:16] == 5'd0) ? 64'd0 : rv);
        e.ill = 1'b0;
        e.res = base + 64'(c34);
        e.rt  = w1[25:21];
        e.wr  = 1'b1;
        e.npc = p + 64'd8;
      end
    end
    return e;
  endfunction

  // Driver: one request per call, back to back
  task automatic drive(string tag, logic [31:0] w0, logic w1v, logic [31:0] w1,
                       logic [63:0] p, logic [63:0] rv);
    @(negedge clk);
    in_valid    = 1'b1;
    word0       = w0;
    word1_valid = w1v;
    word1       = w1;
    pc          = p;
    ra_value    = rv;
    sb_q.push_back(model(w0, w1v, w1, p, rv));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R1 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check64({t, " result"},      out_result,              e.res);
        check64({t, " rt"},          64'(out_rt),             64'(e.rt));
        check64({t, " wr_en"},       64'(out_wr_en),          64'(e.wr));
        check64({t, " next_pc R3"},  out_next_pc,             e.npc);
        check64({t, " illegal"},     64'(out_illegal),        64'(e.ill));
        check64({t, " suffix R4"},   64'(out_suffix_used),    64'(e.used));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check64("R12 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R12 out_valid after reset", 64'(out_valid), 64'd0);

    drive("R2 R7 short ra0",        enc_short(5'd3, 5'd0, 16'h0123), 1'b0, 32'h0, 64'h1000, 64'hDEAD);
    drive("R2 R7 short ra nonzero", enc_short(5'd7, 5'd4, 16'hFFF0), 1'b0, 32'h0, 64'h2000, 64'h100);
    drive("R11 short wrap",         enc_short(5'd1, 5'd9, 16'h0002), 1'b0, 32'h0, 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF);
    drive("R5 R7 long r0 ra0",      enc_pfx(1'b0, 18'h00001), 1'b1, enc_short(5'd3, 5'd0, 16'h1000), 64'h4000, 64'h55);
    drive("R5 R7 long negative",    enc_pfx(1'b0, 18'h3FFFF), 1'b1, enc_short(5'd5, 5'd4, 16'hFFFE), 64'h5000, 64'h6000_0424_17DF_FEFD);
    drive("R6 long pc relative",    enc_pfx(1'b1, 18'h20000), 1'b1, enc_short(5'd2, 5'd0, 16'h0010), 64'h0000_0004_0000_1000, 64'h77);
    drive("R8 rel with base",       enc_pfx(1'b1, 18'h00010), 1'b1, enc_short(5'd2, 5'd6, 16'h0010), 64'h6000, 64'h77);
    idle(2);
    check64("R1 idle out_valid", 64'(out_valid), 64'd0);
    drive("R9 prefix no suffix",    enc_pfx(1'b0, 18'h00010), 1'b0, enc_short(5'd2, 5'd0, 16'h0010), 64'h7000, 64'h1);
    drive("R9 prefix bad suffix",   enc_pfx(1'b0, 18'h00010), 1'b1, {6'd15, 26'h0123456}, 64'h8000, 64'h1);
    drive("R9 R10 unknown opcode",  {6'd31, 26'h0}, 1'b0, 32'h0, 64'h9000, 64'h1);
    drive("R4 short ignores suffix", enc_short(5'd8, 5'd8, 16'h7FFF), 1'b1, 32'hFFFF_FFFF, 64'hA000, 64'h1);
    idle(3);
    check64("R1 all results drained", 64'(sb_q.size()), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule